// File: doc/BRIEF.md
# Audio Sample-Rate Divider Search Engine

This block picks the settings for an audio clock tree. It is given an input clock frequency and a target sample rate, both as 32-bit integers in hertz. It tries a fixed set of root-clock oversampling ratios: 256, 512, 384 and 768, in that order. For each ratio it works out an integer divider and the sample rate that ratio and divider would give. It keeps the ratio whose rate comes closest to the target. All arithmetic is integer and uses one shared restoring divider that runs for many cycles.

A request is made with a single-cycle start pulse. The engine raises busy and works through the candidates one after another. It then reports the chosen ratio, the divider, the achieved rate and two flags, together with a one-cycle done pulse. The results stay on the outputs until the next accepted request. Software or a sequencer reads them and programs the clock generator. Programming the clock generator is not part of this block.

Top module: `rate_search`

## Requirements
- R1: Candidates are tried in the fixed order 256, 512, 384, 768. The reported ratio is the ratio value itself, or 0 when nothing was chosen.
- R2: For each candidate the engine computes the root clock `clk/ratio` and then `q = root/rate` with remainder `m`. The divider is `q+1` when `m > floor(rate/2)` and `q` otherwise, so a remainder of exactly half the rate does not round up.
- R3: A candidate whose rounded divider is 0 or 1 is skipped. It is never reported, and it costs no achieved-rate division.
- R4: The achieved rate of a candidate is `floor(clk/(ratio*divider))`. The product is formed without truncation.
- R5: The deviation is the absolute difference between the achieved rate and the target. The best deviation starts at 2^31-1. A candidate replaces the best only if its deviation is strictly smaller, so an earlier candidate wins a tie.
- R6: The search stops right after the first candidate whose deviation is zero. Later candidates cost no cycles.
- R7: If no candidate is accepted, the nosol flag is 1 and the reported ratio, divider and rate are 0.
- R8: A request with a target rate of 0 runs no search. Done and busy are high in the first cycle after the start edge, with the error flag 1 and the ratio, divider and rate all 0.
- R9: Busy rises on the edge that accepts a start and stays high up to and including the done cycle. A start pulse while busy is ignored: it changes neither the results nor the timing.
- R10: Done is a one-cycle pulse. Each division takes 32 iteration cycles. A skipped candidate costs 68 cycles and an evaluated candidate costs 103 cycles. Done is seen that many cycles after the start edge, summed over the candidates visited.
- R11: After reset, busy, done, nosol and error are 0 and the ratio, divider and rate are 0. While idle with no start, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| clk_freq_i | input | 32 | Input clock frequency, Hz |
| rate_i | input | 32 | Target sample rate, Hz |
| busy_o | output | 1 | Search in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| best_ratio_o | output | 10 | Chosen oversampling ratio, 0 if none |
| best_div_o | output | 32 | Chosen integer divider, 0 if none |
| best_rate_o | output | 32 | Achieved sample rate, 0 if none |
| nosol_o | output | 1 | No candidate was accepted |
| err_o | output | 1 | Request rejected because the target rate was 0 |

## Verification
The time to done depends on the data. A zero-rate request completes in the cycle right after the start edge. Otherwise each skipped candidate adds 68 cycles and each evaluated candidate adds 103 cycles, up to an exact match or the last ratio. The bench computes that cycle count in its own model for every request. It counts clock edges from the edge that samples start and requires done to appear on exactly that count. All outputs are sampled at the falling edge inside the done cycle and again one cycle later, to confirm that done has dropped and the results are held.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned NCAND = 4;
  localparam int unsigned IW    = 2;
  localparam int unsigned RW    = 10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_K1, ST_W1, ST_K2, ST_W2, ST_K3, ST_W3, ST_EV, ST_FIN
  } rs_state_e;

  // Oversampling ratio visited at position i of the search order.
  function automatic logic [RW-1:0] ratio_of(input logic [IW-1:0] i);
    case (i)
      2'd0:    return RW'(256);
      2'd1:    return RW'(512);
      2'd2:    return RW'(384);
      default: return RW'(768);
    endcase
  endfunction
endpackage

// File: rtl/rs_divider.sv
// Restoring divider: one quotient bit per cycle, NW cycles per division.
module rs_divider #(
  parameter int unsigned NW = 32,
  parameter int unsigned DW = 42
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [NW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          done_o
);
  localparam int unsigned CW = $clog2(NW + 1);
  localparam int unsigned MW = NW + DW;

  logic [DW-1:0] rem_q, den_q;
  logic [NW-1:0] quo_q, num_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [DW:0]   shifted, trial;
  logic          fits;

  assign shifted = {rem_q, quo_q[NW-1]};
  assign trial   = shifted - {1'b0, den_q};
  assign fits    = ~trial[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (go_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      num_q  <= num_i;
      den_q  <= den_i;
      cnt_q  <= CW'(NW);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      rem_q  <= fits ? trial[DW-1:0] : shifted[DW-1:0];
      quo_q  <= {quo_q[NW-2:0], fits};
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign done_o = done_q;

  // R4: every finished division satisfies quotient*divisor + remainder = dividend
  a_r4_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (MW'(quo_q) * MW'(den_q) + MW'(rem_q) == MW'(num_q)) && (rem_q < den_q));

  // R10: a new division is never launched while one is running
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (cnt_q == '0));
endmodule

// File: rtl/rs_judge.sv
// Combinational scoring of one candidate: rounding, skip test, deviation.
module rs_judge #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 42
) (
  input  logic          chk_i,
  input  logic [W-1:0]  quo_i,
  input  logic [PW-1:0] rem_i,
  input  logic [W-1:0]  rate_i,
  input  logic [W-1:0]  ach_i,
  input  logic [W-1:0]  best_dev_i,
  output logic [W-1:0]  div_o,
  output logic          skip_o,
  output logic [W-1:0]  dev_o,
  output logic          better_o,
  output logic          exact_o
);
  function automatic logic past_half(input logic [W-1:0] m, input logic [W-1:0] t);
    return m > (t >> 1);
  endfunction

  function automatic logic [W-1:0] gap(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  always_comb begin
    div_o    = quo_i + W'(past_half(rem_i[W-1:0], rate_i));
    skip_o   = (div_o <= W'(1));
    dev_o    = gap(ach_i, rate_i);
    better_o = (dev_o < best_dev_i);
    exact_o  = (dev_o == '0);
  end

  // R2: the remainder of the rate division is always below the rate
  always_comb begin
    if (chk_i) begin
      a_r2_rem_bounded: assert (rem_i < PW'(rate_i));
    end
  end
endmodule

// File: rtl/rate_search.sv
module rate_search
  import rs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  clk_freq_i,
  input  logic [W-1:0]  rate_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [RW-1:0] best_ratio_o,
  output logic [W-1:0]  best_div_o,
  output logic [W-1:0]  best_rate_o,
  output logic          nosol_o,
  output logic          err_o
);
  localparam int unsigned PW = W + RW;
  localparam logic [W-1:0] DEV_INIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [IW-1:0] LAST_IDX = IW'(NCAND - 1);

  rs_state_e     st_q;
  logic [W-1:0]  clk_q, rate_q, fs_q, div_q, ach_q, best_dev_q;
  logic [IW-1:0] idx_q;
  logic          found_q, nosol_q, err_q;
  logic [RW-1:0] ratio_q;
  logic [W-1:0]  bdiv_q, brate_q;

  // internal events brought out for the assertions
  logic          dv_go, dv_done;
  logic [W-1:0]  dv_num, dv_quo;
  logic [PW-1:0] dv_den, dv_rem;
  logic [RW-1:0] cur_ratio;
  logic [W-1:0]  div_rnd, cand_dev;
  logic          cand_skip, cand_better, cand_exact, last_cand, rate_chk;

  assign cur_ratio = ratio_of(idx_q);
  assign last_cand = (idx_q == LAST_IDX);
  assign dv_go     = (st_q == ST_K1) || (st_q == ST_K2) || (st_q == ST_K3);
  assign rate_chk  = dv_done && (st_q == ST_W2);

  always_comb begin
    dv_num = clk_q;
    dv_den = PW'(cur_ratio);
    case (st_q)
      ST_K2:   begin dv_num = fs_q; dv_den = PW'(rate_q); end
      ST_K3:   dv_den = PW'(cur_ratio) * PW'(div_q);
      default: ;
    endcase
  end

  rs_divider #(.NW(W), .DW(PW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (dv_go),
    .num_i (dv_num),
    .den_i (dv_den),
    .quo_o (dv_quo),
    .rem_o (dv_rem),
    .done_o(dv_done)
  );

  rs_judge #(.W(W), .PW(PW)) u_judge (
    .chk_i     (rate_chk),
    .quo_i     (dv_quo),
    .rem_i     (dv_rem),
    .rate_i    (rate_q),
    .ach_i     (ach_q),
    .best_dev_i(best_dev_q),
    .div_o     (div_rnd),
    .skip_o    (cand_skip),
    .dev_o     (cand_dev),
    .better_o  (cand_better),
    .exact_o   (cand_exact)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      clk_q      <= '0;
      rate_q     <= '0;
      fs_q       <= '0;
      div_q      <= '0;
      ach_q      <= '0;
      best_dev_q <= DEV_INIT;
      idx_q      <= '0;
      found_q    <= 1'b0;
      nosol_q    <= 1'b0;
      err_q      <= 1'b0;
      ratio_q    <= '0;
      bdiv_q     <= '0;
      brate_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          ratio_q    <= '0;
          bdiv_q     <= '0;
          brate_q    <= '0;
          nosol_q    <= 1'b0;
          found_q    <= 1'b0;
          best_dev_q <= DEV_INIT;
          idx_q      <= '0;
          if (rate_i == '0) begin
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end else begin
            err_q  <= 1'b0;
            clk_q  <= clk_freq_i;
            rate_q <= rate_i;
            st_q   <= ST_K1;
          end
        end
        ST_K1: st_q <= ST_W1;
        ST_W1: if (dv_done) begin
          fs_q <= dv_quo;
          st_q <= ST_K2;
        end
        ST_K2: st_q <= ST_W2;
        ST_W2: if (dv_done) begin
          if (!cand_skip) begin
            div_q <= div_rnd;
            st_q  <= ST_K3;
          end else if (last_cand) begin
            nosol_q <= ~found_q;
            st_q    <= ST_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_K1;
          end
        end
        ST_K3: st_q <= ST_W3;
        ST_W3: if (dv_done) begin
          ach_q <= dv_quo;
          st_q  <= ST_EV;
        end
        ST_EV: begin
          if (cand_better) begin
            best_dev_q <= cand_dev;
            ratio_q    <= cur_ratio;
            bdiv_q     <= div_q;
            brate_q    <= ach_q;
            found_q    <= 1'b1;
          end
          if (cand_exact || last_cand) begin
            nosol_q <= ~(found_q | cand_better);
            st_q    <= ST_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_K1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_FIN);
  assign best_ratio_o = ratio_q;
  assign best_div_o   = bdiv_q;
  assign best_rate_o  = brate_q;
  assign nosol_o      = nosol_q;
  assign err_o        = err_q;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  a_r8_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && rate_i == '0) |=> (done_o && err_o && best_ratio_o == '0));

  a_r7_nosol_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && nosol_o) |-> (best_ratio_o == '0 && best_div_o == '0 && best_rate_o == '0));

  a_r3_div_above_one: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !nosol_o && !err_o) |-> (best_div_o > W'(1)));

  a_r5_dev_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (best_dev_q <= $past(best_dev_q)));

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(best_ratio_o) && $stable(best_div_o) &&
                               $stable(best_rate_o) && $stable(nosol_o) && $stable(err_o)));
endmodule

// File: tb/rate_search_tb_top.sv
`timescale 1ns/1ps
module rate_search_tb_top;
  localparam int W = 32;
  localparam int SKIP_CYC = 2*W + 4;
  localparam int EVAL_CYC = 3*W + 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cf = '0, rt = '0;
  logic        busy, done, nosol, err;
  logic [9:0]  ratio;
  logic [31:0] bdiv, brate;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rate_search #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clk_freq_i(cf), .rate_i(rt),
    .busy_o(busy), .done_o(done), .best_ratio_o(ratio), .best_div_o(bdiv),
    .best_rate_o(brate), .nosol_o(nosol), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Independent arithmetic model of the search and of its cycle cost.
  function automatic void model(input longint unsigned c, input longint unsigned r,
                                output longint unsigned o_ratio, output longint unsigned o_div,
                                output longint unsigned o_rate, output bit o_nosol,
                                output int o_cyc);
    longint unsigned tab[4] = '{256, 512, 384, 768};
    longint unsigned best = 64'h7FFF_FFFF;
    longint unsigned fs, d, a, dv;
    o_ratio = 0; o_div = 0; o_rate = 0; o_nosol = 1'b1; o_cyc = 0;
    for (int k = 0; k < 4; k++) begin
      fs = c / tab[k];
      d  = fs / r;
      if (2 * (fs % r) > r) d = d + 1;
      if (d < 2) begin
        o_cyc += SKIP_CYC;
        continue;
      end
      o_cyc += EVAL_CYC;
      a  = c / (tab[k] * d);
      dv = (a > r) ? a - r : r - a;
      if (dv < best) begin
        best = dv; o_ratio = tab[k]; o_div = d; o_rate = a; o_nosol = 1'b0;
      end
      if (dv == 0) break;
    end
  endfunction

  task automatic run(input longint unsigned c, input longint unsigned r, input bit intrude);
    longint unsigned e_ratio, e_div, e_rate;
    bit e_nosol;
    int e_cyc;
    int n;
    logic [9:0]  h_ratio;
    logic [31:0] h_div;
    model(c, r, e_ratio, e_div, e_rate, e_nosol, e_cyc);
    @(negedge clk);
    cf = c[31:0]; rt = r[31:0]; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after accepted start", busy, 1);
    n = 0;
    while (!done && n < 2000) begin
      // R9: a second request while busy must be ignored
      if (intrude && n == 40) begin
        cf = ~c[31:0]; rt = r[31:0] + 32'd7; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R10 done arrived", done, 1);
    chk(n == e_cyc, "R6/R10 cycles to done", n, e_cyc);
    chk(busy === 1'b1, "R9 busy in done cycle", busy, 1);
    chk(ratio == e_ratio[9:0], "R1/R5 chosen ratio", ratio, e_ratio);
    chk(bdiv == e_div[31:0], "R2/R3 chosen divider", bdiv, e_div);
    chk(brate == e_rate[31:0], "R4 achieved rate", brate, e_rate);
    chk(nosol == e_nosol, "R7 no-solution flag", nosol, e_nosol);
    chk(err == 1'b0, "R8 error flag clear", err, 0);
    h_ratio = ratio; h_div = bdiv;
    @(negedge clk);
    chk(done == 1'b0, "R10 done is one cycle", done, 0);
    chk(busy == 1'b0, "R9 busy drops after done", busy, 0);
    cf = 32'h1234_5678; rt = 32'd1;
    repeat (3) @(negedge clk);
    chk(ratio == h_ratio && bdiv == h_div, "R11 results held while idle", bdiv, h_div);
  endtask

  task automatic run_zero();
    @(negedge clk);
    cf = 32'd49_152_000; rt = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, "R8 zero rate done at once", done, 1);
    chk(busy === 1'b1, "R8 busy in done cycle", busy, 1);
    chk(err === 1'b1, "R8 error flag", err, 1);
    chk(ratio == 0 && bdiv == 0 && brate == 0, "R8 zeroed results", bdiv, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 back to idle", busy, 0);
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    checks++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(busy == 0, "R11 reset busy", busy, 0);
    chk(done == 0, "R11 reset done", done, 0);
    chk(ratio == 0, "R11 reset ratio", ratio, 0);
    chk(bdiv == 0, "R11 reset divider", bdiv, 0);
    chk(brate == 0, "R11 reset rate", brate, 0);
    chk(nosol == 0 && err == 0, "R11 reset flags", {nosol, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(64'd49_152_000, 64'd48_000, 1'b0);   // R6 exact on first ratio
    run(64'd12_288_000, 64'd48_000, 1'b0);   // R3/R7 every divider <= 1
    run(64'd30_720_000, 64'd48_000, 1'b0);   // R2 remainder exactly half
    run(64'd100_000_000, 64'd44_100, 1'b0);
    run(64'hFFFF_FFFF, 64'd1, 1'b0);          // R4 widest product
    run(64'd1_000_000, 64'hFFFF_FFFF, 1'b0);  // R7 huge target
    run(64'd73_728_000, 64'd48_000, 1'b1);   // R9 intruding start
    run_zero();                               // R8
    run(64'd36_864_000, 64'd32_000, 1'b1);

    lcg = 32'hC0FF_EE11;
    for (int i = 0; i < 40; i++) begin
      longint unsigned c, r;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      c = {32'd0, lcg};
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      r = 64'd8000 + (lcg % 32'd192000);
      run(c, r, (i % 7) == 3);               // R1/R5 order and tie handling
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule